// File: doc/BRIEF.md
# Baud-Rate Second-Order Timing Recovery Loop

This block is the digital half of a clock and data recovery loop for a receiver that samples each bit once, at its centre. Behind a decision feedback equalizer a sample taken at the bit edge has not settled, so no edge sampler is used. Timing error comes only from the data decisions and from the signs of the error slicer at the bit centres. The block runs on the quarter-rate clock. Each cycle it takes four consecutive sample pairs, each pair being a data bit and an error sign. For each sample it forms a sign-sign Mueller-Müller style timing error. A majority vote reduces the four errors to one early, late or hold decision.

The decision drives a proportional-plus-integral loop. A saturating signed frequency integrator tracks a small rate offset between the transmitter and the local reference. A phase accumulator with fractional bits adds the proportional step and the frequency term every cycle. The six integer bits of the phase accumulator are the interpolator code: 64 steps per bit time, wrapping at the ends. Two shift-type gains set the proportional and integral bandwidths. The frequency integrator is readable at a port.

Top module: `cdr_baud_loop`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `phase_code` is 0 and `freq_word` is 0.
- R2: Lane i of `smp_d`/`smp_e` is sample i of the group, and lane 0 is the earliest. A data bit 1 means +1 and 0 means −1. An error bit 1 means a positive error and 0 a negative one. The per-sample error is (E[k]·D[k−1] − E[k−1]·D[k]) / 2, which takes the values −1, 0 or +1.
- R3: For lane 0, sample k−1 is lane 3 of the last group accepted with `loop_en` high. After reset that previous sample is taken as data 0 and error 0.
- R4: The group decision is the sign of the sum of the four per-sample errors. A tie, which includes a 2–2 split, gives a decision of 0: no proportional step and no frequency change.
- R5: On an accepted group the frequency word becomes freq + decision·2^`kf_shift`. It saturates at −2048 and +2047 (12-bit signed).
- R6: On an accepted group the 14-bit phase accumulator becomes acc + decision·2^`kp_shift` + freq, where freq is the value before this update. The accumulator has 8 fractional bits, and `phase_code` is its top 6 bits.
- R7: The phase accumulator wraps modulo 2^14, so `phase_code` wraps from 63 to 0 and from 0 to 63.
- R8: With `loop_en` low, neither `phase_code`, `freq_word` nor the lane-0 history changes, whatever the sample inputs carry.
- R9: The gains are applied in the same cycle as the sample group they accompany. Results appear one clock edge after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loop_en | input | 1 | Accept the present sample group |
| smp_d | input | 4 | Data decisions, lane 0 earliest |
| smp_e | input | 4 | Error signs, lane 0 earliest |
| kp_shift | input | 3 | Proportional gain as a power of two, in accumulator LSBs |
| kf_shift | input | 3 | Integral gain as a power of two, in frequency LSBs |
| phase_code | output | 6 | Interpolator phase code |
| freq_word | output | 12 | Frequency integrator readback, signed |

## Verification
Both results are registered once. The code and the frequency word that follow from a sample group are visible one edge after that group is presented. The bench drives every group on the falling edge. On the next falling edge it compares both outputs with a behavioural model that has already advanced over the same group. The internal reset release takes two cycles, so the bench holds `loop_en` low over that window. After the window it checks the cleared state. Saturation and wrap are reached with stimulus chosen by the model to force a given decision, so these boundary values are known exactly when they are checked.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // Ternary timing decision: -1, 0 or +1
  typedef logic signed [1:0] tern_t;
  localparam tern_t TERN_NEG  = -2'sd1;
  localparam tern_t TERN_ZERO = 2'sd0;
  localparam tern_t TERN_POS  = 2'sd1;
endpackage

// File: rtl/mm_pd_slice.sv
module mm_pd_slice
  import cdr_pkg::*;
(
  input  logic  d_cur,
  input  logic  e_cur,
  input  logic  d_prv,
  input  logic  e_prv,
  output tern_t pd
);
  logic lead_pos;
  logic lag_pos;

  // Products of +/-1 values reduce to an equality test of the bits
  always_comb begin
    lead_pos = (e_cur == d_prv);
    lag_pos  = (e_prv == d_cur);
    if (lead_pos == lag_pos) pd = TERN_ZERO;
    else if (lead_pos)       pd = TERN_POS;
    else                     pd = TERN_NEG;
  end
endmodule

// File: rtl/vote_reduce.sv
module vote_reduce
  import cdr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  tern_t pd_in [LANES],
  output tern_t vote
);
  localparam int SUM_W = $clog2(LANES + 1) + 1;

  logic signed [SUM_W-1:0] tally;

  always_comb begin
    tally = '0;
    for (int i = 0; i < LANES; i++) begin
      tally = tally + SUM_W'(pd_in[i]);
    end
    if (tally > 0)      vote = TERN_POS;
    else if (tally < 0) vote = TERN_NEG;
    else                vote = TERN_ZERO;
  end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import cdr_pkg::*;
#(
  parameter int ACC_W      = 14,
  parameter int FREQ_BITS  = 12,
  parameter int SHIFT_BITS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  tern_t                       vote,
  input  logic [SHIFT_BITS-1:0]       kp_shift,
  input  logic [SHIFT_BITS-1:0]       kf_shift,
  output logic [ACC_W-1:0]            acc_q,
  output logic signed [FREQ_BITS-1:0] freq_q
);
  localparam int FX_W = FREQ_BITS + 1;
  localparam logic signed [FX_W-1:0] F_MAX = FX_W'((1 <<< (FREQ_BITS - 1)) - 1);
  localparam logic signed [FX_W-1:0] F_MIN = -FX_W'(1 <<< (FREQ_BITS - 1));

  logic [ACC_W-1:0]            acc_d;
  logic signed [FREQ_BITS-1:0] freq_d;
  logic signed [FX_W-1:0]      fstep;
  logic signed [FX_W-1:0]      fsum;
  logic [ACC_W-1:0]            pstep;
  logic [ACC_W-1:0]            fext;

  always_comb begin
    fstep = FX_W'(1) <<< kf_shift;
    pstep = ACC_W'(1) << kp_shift;
    fext  = {{(ACC_W - FREQ_BITS){freq_q[FREQ_BITS-1]}}, freq_q};
    acc_d  = acc_q;
    freq_d = freq_q;
    fsum   = {freq_q[FREQ_BITS-1], freq_q};
    if (en) begin
      unique case (vote)
        TERN_POS: begin
          fsum  = {freq_q[FREQ_BITS-1], freq_q} + fstep;
          acc_d = acc_q + pstep + fext;
        end
        TERN_NEG: begin
          fsum  = {freq_q[FREQ_BITS-1], freq_q} - fstep;
          acc_d = acc_q - pstep + fext;
        end
        default: begin
          acc_d = acc_q + fext;
        end
      endcase
      if (fsum > F_MAX)      freq_d = F_MAX[FREQ_BITS-1:0];
      else if (fsum < F_MIN) freq_d = F_MIN[FREQ_BITS-1:0];
      else                   freq_d = fsum[FREQ_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      freq_q <= '0;
    end else if (en) begin
      acc_q  <= acc_d;
      freq_q <= freq_d;
    end
  end
endmodule

// File: rtl/cdr_baud_loop.sv
module cdr_baud_loop
  import cdr_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int CODE_BITS  = 6,
  parameter int FRAC_BITS  = 8,
  parameter int FREQ_BITS  = 12,
  parameter int SHIFT_BITS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        loop_en,
  input  logic [LANES-1:0]            smp_d,
  input  logic [LANES-1:0]            smp_e,
  input  logic [SHIFT_BITS-1:0]       kp_shift,
  input  logic [SHIFT_BITS-1:0]       kf_shift,
  output logic [CODE_BITS-1:0]        phase_code,
  output logic signed [FREQ_BITS-1:0] freq_word
);
  localparam int ACC_W = CODE_BITS + FRAC_BITS;

  logic             rst_meta;
  logic             rst_q;
  logic             d_hist;
  logic             e_hist;
  logic [LANES:0]   d_chain;
  logic [LANES:0]   e_chain;
  tern_t            pd_lane [LANES];
  tern_t            vote;
  logic [ACC_W-1:0] acc_q;
  logic signed [FREQ_BITS-1:0] freq_q;

  // Asynchronous assertion, two-stage synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Last sample of the previous accepted group
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      d_hist <= 1'b0;
      e_hist <= 1'b0;
    end else if (loop_en) begin
      d_hist <= smp_d[LANES-1];
      e_hist <= smp_e[LANES-1];
    end
  end

  assign d_chain = {smp_d, d_hist};
  assign e_chain = {smp_e, e_hist};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mm_pd_slice u_pd (
      .d_cur (d_chain[g+1]),
      .e_cur (e_chain[g+1]),
      .d_prv (d_chain[g]),
      .e_prv (e_chain[g]),
      .pd    (pd_lane[g])
    );
  end

  vote_reduce #(.LANES(LANES)) u_vote (
    .pd_in (pd_lane),
    .vote  (vote)
  );

  pi_loop_filter #(
    .ACC_W      (ACC_W),
    .FREQ_BITS  (FREQ_BITS),
    .SHIFT_BITS (SHIFT_BITS)
  ) u_loop (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (loop_en),
    .vote     (vote),
    .kp_shift (kp_shift),
    .kf_shift (kf_shift),
    .acc_q    (acc_q),
    .freq_q   (freq_q)
  );

  assign phase_code = acc_q[ACC_W-1 -: CODE_BITS];
  assign freq_word  = freq_q;
endmodule

// File: rtl/cdr_loop_checker.sv
module cdr_loop_checker #(
  parameter int ACC_W     = 14,
  parameter int FREQ_BITS = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        en,
  input logic signed [1:0]           vote,
  input logic [ACC_W-1:0]            acc,
  input logic signed [FREQ_BITS-1:0] freq
);
  localparam logic signed [FREQ_BITS-1:0] F_MAX = FREQ_BITS'((1 <<< (FREQ_BITS - 1)) - 1);
  localparam logic signed [FREQ_BITS-1:0] F_MIN = -FREQ_BITS'(1 <<< (FREQ_BITS - 1));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc == '0 && freq == '0));

  assert_vote_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vote != 2'sb10);

  assert_tie_freq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vote == 2'sd0) |=> $stable(freq));

  assert_freq_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vote == 2'sd1 && freq != F_MAX) |=> (freq > $past(freq)));

  assert_freq_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vote == -2'sd1 && freq != F_MIN) |=> (freq < $past(freq)));

  assert_freq_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vote == 2'sd1 && freq == F_MAX) |=> (freq == F_MAX));

  assert_phase_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vote == 2'sd0 && freq == '0) |=> $stable(acc));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(freq) && $stable(acc)));
endmodule

bind cdr_baud_loop cdr_loop_checker #(
  .ACC_W     (ACC_W),
  .FREQ_BITS (FREQ_BITS)
) chk_i (
  .clk   (clk),
  .rst_n (rst_q),
  .en    (loop_en),
  .vote  (vote),
  .acc   (acc_q),
  .freq  (freq_q)
);

// File: tb/cdr_baud_loop_tb.sv
module cdr_baud_loop_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       loop_en;
  logic [3:0] smp_d, smp_e;
  logic [2:0] kp_shift, kf_shift;
  logic [5:0] phase_code;
  logic signed [11:0] freq_word;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  // reference model state
  int m_acc = 0;
  int m_freq = 0;
  int m_dp = 0;
  int m_ep = 0;
  int wraps = 0;

  always #5 clk = ~clk;

  cdr_baud_loop dut_i (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .smp_d(smp_d), .smp_e(smp_e),
    .kp_shift(kp_shift), .kf_shift(kf_shift),
    .phase_code(phase_code), .freq_word(freq_word)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pm(input int b);
    return b ? 1 : -1;
  endfunction

  // Decision of a group given the history bits (from the requirement formula)
  function automatic int model_vote(input int d, input int e, input int dp, input int ep);
    int sum = 0;
    int pd_prev = dp;
    int pe_prev = ep;
    for (int i = 0; i < 4; i++) begin
      int dk = (d >> i) & 1;
      int ek = (e >> i) & 1;
      sum += (pm(ek) * pm(pd_prev) - pm(pe_prev) * pm(dk)) / 2;
      pd_prev = dk;
      pe_prev = ek;
    end
    return (sum > 0) ? 1 : ((sum < 0) ? -1 : 0);
  endfunction

  task automatic cycle(input bit en, input int d, input int e, input int kp, input int kf);
    int v;
    int prev_code;
    loop_en = en; smp_d = d[3:0]; smp_e = e[3:0];
    kp_shift = kp[2:0]; kf_shift = kf[2:0];
    prev_code = m_acc >> 8;
    if (en) begin
      v = model_vote(d, e, m_dp, m_ep);
      m_acc = (((m_acc + v * (1 << kp) + m_freq) % 16384) + 16384) % 16384;
      m_freq = m_freq + v * (1 << kf);
      if (m_freq > 2047) m_freq = 2047;
      if (m_freq < -2048) m_freq = -2048;
      m_dp = (d >> 3) & 1;
      m_ep = (e >> 3) & 1;
      if ((prev_code >= 56 && (m_acc >> 8) < 8) || (prev_code < 8 && (m_acc >> 8) >= 56))
        wraps++;
    end
    @(negedge clk);
    check_eq({cur_req, " phase_code"}, int'(phase_code), m_acc >> 8);
    check_eq({cur_req, " freq_word"}, int'(freq_word), m_freq);
  endtask

  // Pick a group that forces the wanted decision from the present history
  task automatic force_vote(input int want, input int kp, input int kf);
    for (int c = 0; c < 256; c++) begin
      if (model_vote(c & 15, c >> 4, m_dp, m_ep) == want) begin
        cycle(1'b1, c & 15, c >> 4, kp, kf);
        return;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fr_hold;
    int code_hold;
    rst_n = 1'b0; loop_en = 1'b0; smp_d = '0; smp_e = '0; kp_shift = '0; kf_shift = '0;
    repeat (3) @(negedge clk);
    // R1: cleared state during reset
    check_eq("R1 reset code", int'(phase_code), 0);
    check_eq("R1 reset freq", int'(freq_word), 0);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (3) cycle(1'b0, 4'hF, 4'h0, 0, 0);

    // R2 and R3: first groups after reset use the cleared history
    cur_req = "R3";
    cycle(1'b1, 4'b0001, 4'b0001, 7, 0);
    cur_req = "R2";
    cycle(1'b1, 4'b1010, 4'b0110, 7, 0);
    cycle(1'b1, 4'b1100, 4'b0011, 6, 1);
    cycle(1'b1, 4'b0111, 4'b1101, 5, 2);
    for (int i = 0; i < 16; i++) cycle(1'b1, i, 15 - i, 4, 1);

    // R4: ties leave the frequency and the proportional step alone
    cur_req = "R4";
    force_vote(1, 0, 3);
    fr_hold = m_freq;
    force_vote(0, 7, 7);
    check_eq("R4 tie freq", int'(freq_word), fr_hold);
    force_vote(0, 7, 7);

    // R5: saturate upward then downward
    cur_req = "R5";
    repeat (20) force_vote(1, 2, 7);
    check_eq("R5 freq max", int'(freq_word), 2047);
    cur_req = "R7";
    repeat (20) force_vote(0, 0, 0);
    cur_req = "R5";
    repeat (40) force_vote(-1, 3, 7);
    check_eq("R5 freq min", int'(freq_word), -2048);
    cur_req = "R7";
    repeat (20) force_vote(0, 0, 0);
    checks++;
    if (wraps == 0) begin
      errors++;
      $display("FAIL R7: actual %0d wraps expected at least 1", wraps);
    end

    // R8: disabled cycles change nothing, history kept for the next group
    cur_req = "R8";
    code_hold = m_acc >> 8;
    fr_hold = m_freq;
    for (int i = 0; i < 10; i++) cycle(1'b0, $urandom_range(15), $urandom_range(15), 7, 7);
    check_eq("R8 idle code", int'(phase_code), code_hold);
    check_eq("R8 idle freq", int'(freq_word), fr_hold);
    cycle(1'b1, 4'b0110, 4'b1001, 3, 3);

    // R6 and R9: random data, gains and enable
    cur_req = "R9";
    for (int i = 0; i < 3000; i++)
      cycle($urandom_range(9) != 0, $urandom_range(15), $urandom_range(15),
            $urandom_range(7), $urandom_range(7));
    cur_req = "R6";
    for (int i = 0; i < 2000; i++)
      cycle(1'b1, $urandom_range(15), $urandom_range(15), 5, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule